// File: doc/BRIEF.md
# ATA Task-File Register Front End

This block is the device side of an ATA command block: eight byte-wide register offsets that a host reads and writes with single-cycle strobes. Offsets 2 to 6 hold the sector count, the three LBA bytes and the device/head selector as plain readable storage. Offset 7 is the status register on a read and the command register on a write. Offset 0 is the 16-bit PIO data port, and offset 1 returns the error register on a read and takes a feature byte on a write. The feature byte is decoded but has no storage, because no supported command uses it.

A small command engine sits behind the command register and runs two commands. IDENTIFY DEVICE (0xEC) opens a PIO data-in phase that delivers exactly 256 words, which are computed on the fly from parameters. FLUSH CACHE (0xE7) keeps the device busy until a one-cycle completion pulse arrives from the backing-store model. Any other opcode is rejected with an abort error. When a command finishes, the engine raises an interrupt request, and a host read of the status register drops it again. The data-request output follows the PIO data phase.

Top module: `taskfile_front`

## Requirements
- R1: After reset the status register (offset 7) reads 0x40 (DRDY only), `irq` and `drq_out` are low, and offsets 2 to 6 read 0.
- R2: A write to offset 2, 3, 4, 5 or 6 stores the low byte, and a read of that offset returns it zero-extended to 16 bits.
- R3: Writing 0xEC in the idle state starts a PIO phase. The status reads 0x48 (DRDY|DRQ) and `drq_out` is high until exactly 256 reads of offset 0 have been made. After the 256th read the status reads 0x40 and `drq_out` is low.
- R4: The IDENTIFY words are returned in index order 0 to 255. Word 0 is 0x0040. Words 10 to 19 carry the 20-character serial parameter, and words 23 to 26 carry the 8-character version parameter, two characters per word with the earlier character in bits 15:8. Word 85 is 0x0020 (write cache enabled). Every other word is 0.
- R5: Command completion sets `irq`. Completion means the 256th data read, a flush completion pulse, or the rejection of an unsupported opcode.
- R6: A read strobe at offset 7 clears `irq` on the following edge.
- R7: Writing 0xE7 in the idle state makes the status read 0xC0 (BSY|DRDY) until a `flush_done` pulse arrives. After that pulse the status reads 0x40 and `irq` is set.
- R8: Any other opcode written in the idle state makes the status read 0x41 (DRDY|ERR) and the error register (offset 1) read 0x0004 (abort, bit 2). The next accepted command clears both the ERR bit and the abort bit.
- R9: A command write while a PIO phase or a flush is in progress is ignored. The status, the word position and the error state are all left unchanged.
- R10: While bit 4 of the device register is set (device 1, which is absent), status reads 0x00 and command writes are ignored.
- R11: A read of offset 0 outside a PIO phase returns 0 and changes no state.
- R12: A `flush_done` pulse when no flush is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Register write strobe, one cycle |
| host_rd | input | 1 | Register read strobe, one cycle; side effects apply at the edge |
| host_addr | input | 3 | Register offset 0 to 7 |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 16 | Read data for `host_addr`, combinational from state |
| flush_done | input | 1 | Flush completion pulse from the backing store |
| irq | output | 1 | Interrupt request |
| drq_out | output | 1 | Data request, high during the PIO data-in phase |

## Verification
The hardest situations to reach from the ports are a command write that arrives in the middle of a long PIO stream and a stray completion pulse while the engine is idle. Neither occurs in ordinary traffic. The stimulus reaches the first case by issuing a FLUSH CACHE opcode partway through the 256-word IDENTIFY stream, then draining the remaining words and checking that no word is skipped. It reaches the second case by pulsing `flush_done` with nothing pending. A behavioural model in the bench follows every strobe and compares the read data, `irq` and `drq_out` on every clock, so a corrupted word index or a dropped interrupt shows up on the cycle where it happens.

// File: rtl/tf_pkg.sv
package tf_pkg;
   localparam logic [2:0] OFS_DATA   = 3'd0;
   localparam logic [2:0] OFS_ERRFT  = 3'd1;
   localparam logic [2:0] OFS_STAT   = 3'd7;

   localparam logic [7:0] ST_BSY  = 8'h80;
   localparam logic [7:0] ST_DRDY = 8'h40;
   localparam logic [7:0] ST_DRQ  = 8'h08;
   localparam logic [7:0] ST_ERR  = 8'h01;

   localparam logic [7:0] ERR_ABORT = 8'h04;

   localparam logic [7:0] OP_IDENT = 8'hEC;
   localparam logic [7:0] OP_FLUSH = 8'hE7;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_PIO   = 2'd1,
      PH_FLUSH = 2'd2
   } phase_t;
endpackage

// File: rtl/tf_shadow.sv
module tf_shadow #(
   parameter int NREG = 5,
   parameter int BASE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [2:0]        addr,
   input  logic [7:0]        wdata,
   output logic [8*NREG-1:0] regs
);
   if (BASE + NREG > 7) begin : g_bad_range
      $error("tf_shadow: shadow registers overlap the command offset");
   end

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[8*g +: 8] <= '0;
         else if (wr && addr == 3'(BASE + g))
            regs[8*g +: 8] <= wdata;
      end
   end
endmodule

// File: rtl/tf_ident_rom.sv
module tf_ident_rom #(
   parameter int IDX_W       = 8,
   parameter int SER_CHARS   = 20,
   parameter int VER_CHARS   = 8,
   parameter int SER_BASE    = 10,
   parameter int VER_BASE    = 23,
   parameter int WCACHE_WORD = 85,
   parameter logic [8*SER_CHARS-1:0] SERIAL_STR  = "TF-UNIT-0000000001AB",
   parameter logic [8*VER_CHARS-1:0] VERSION_STR = "REV1.00 "
) (
   input  logic [IDX_W-1:0] idx,
   output logic [15:0]      word
);
   localparam int SER_WORDS = SER_CHARS / 2;
   localparam int VER_WORDS = VER_CHARS / 2;

   if ((SER_CHARS % 2) != 0 || (VER_CHARS % 2) != 0) begin : g_odd
      $error("tf_ident_rom: string lengths must be even");
   end

   always_comb begin
      word = '0;
      if (idx == '0)
         word = 16'h0040;
      for (int k = 0; k < SER_WORDS; k++)
         if (idx == IDX_W'(SER_BASE + k))
            word = SERIAL_STR[8*SER_CHARS-1-16*k -: 16];
      for (int k = 0; k < VER_WORDS; k++)
         if (idx == IDX_W'(VER_BASE + k))
            word = VERSION_STR[8*VER_CHARS-1-16*k -: 16];
      if (idx == IDX_W'(WCACHE_WORD))
         word = 16'h0020;
   end
endmodule

// File: rtl/tf_engine.sv
module tf_engine
   import tf_pkg::*;
#(
   parameter int ID_WORDS = 256,
   localparam int IDX_W   = $clog2(ID_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [7:0]       cmd_op,
   input  logic             dev1_sel,
   input  logic             data_rd,
   input  logic             stat_rd,
   input  logic             flush_done,
   output phase_t           phase,
   output logic [IDX_W-1:0] idx,
   output logic             err,
   output logic             irq
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ID_WORDS - 1);

   phase_t           ph_d;
   logic [IDX_W-1:0] idx_d;
   logic             err_d;
   logic             done;

   always_comb begin
      ph_d  = phase;
      idx_d = idx;
      err_d = err;
      done  = 1'b0;
      unique case (phase)
         PH_IDLE: begin
            if (cmd_wr && !dev1_sel) begin
               if (cmd_op == OP_IDENT) begin
                  ph_d  = PH_PIO;
                  idx_d = '0;
                  err_d = 1'b0;
               end else if (cmd_op == OP_FLUSH) begin
                  ph_d  = PH_FLUSH;
                  err_d = 1'b0;
               end else begin
                  err_d = 1'b1;
                  done  = 1'b1;
               end
            end
         end
         PH_PIO: begin
            if (data_rd) begin
               if (idx == LAST) begin
                  ph_d = PH_IDLE;
                  done = 1'b1;
               end else begin
                  idx_d = idx + 1'b1;
               end
            end
         end
         PH_FLUSH: begin
            if (flush_done) begin
               ph_d = PH_IDLE;
               done = 1'b1;
            end
         end
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         idx   <= '0;
         err   <= 1'b0;
         irq   <= 1'b0;
      end else begin
         phase <= ph_d;
         idx   <= idx_d;
         err   <= err_d;
         if (done)
            irq <= 1'b1;
         else if (stat_rd)
            irq <= 1'b0;
      end
   end
endmodule

// File: rtl/taskfile_front.sv
module taskfile_front
   import tf_pkg::*;
#(
   parameter int ID_WORDS    = 256,
   parameter int SER_CHARS   = 20,
   parameter int VER_CHARS   = 8,
   parameter int SER_BASE    = 10,
   parameter int VER_BASE    = 23,
   parameter int WCACHE_WORD = 85,
   parameter logic [8*SER_CHARS-1:0] SERIAL_STR  = "TF-UNIT-0000000001AB",
   parameter logic [8*VER_CHARS-1:0] VERSION_STR = "REV1.00 "
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_wr,
   input  logic        host_rd,
   input  logic [2:0]  host_addr,
   input  logic [7:0]  host_wdata,
   output logic [15:0] host_rdata,
   input  logic        flush_done,
   output logic        irq,
   output logic        drq_out
);
   localparam int IDX_W   = $clog2(ID_WORDS);
   localparam int NSHADOW = 5;
   localparam int DEV_BIT = 8 * 4 + 4;

   if (ID_WORDS <= WCACHE_WORD || SER_BASE + SER_CHARS / 2 > ID_WORDS ||
       VER_BASE + VER_CHARS / 2 > ID_WORDS) begin : g_bad_layout
      $error("taskfile_front: IDENTIFY layout does not fit ID_WORDS");
   end

   logic [8*NSHADOW-1:0] shadow;
   phase_t               phase;
   logic [IDX_W-1:0]     idx;
   logic                 err;
   logic [15:0]          id_word;
   logic                 dev1_sel;
   logic                 busy_w;
   logic [7:0]           status;

   assign dev1_sel = shadow[DEV_BIT];
   assign busy_w   = (phase == PH_FLUSH);
   assign drq_out  = (phase == PH_PIO);

   tf_shadow #(.NREG(NSHADOW), .BASE(2)) u_shadow (
      .clk(clk), .rst_n(rst_n), .wr(host_wr), .addr(host_addr),
      .wdata(host_wdata), .regs(shadow)
   );

   tf_ident_rom #(
      .IDX_W(IDX_W), .SER_CHARS(SER_CHARS), .VER_CHARS(VER_CHARS),
      .SER_BASE(SER_BASE), .VER_BASE(VER_BASE), .WCACHE_WORD(WCACHE_WORD),
      .SERIAL_STR(SERIAL_STR), .VERSION_STR(VERSION_STR)
   ) u_rom (
      .idx(idx), .word(id_word)
   );

   tf_engine #(.ID_WORDS(ID_WORDS)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .cmd_wr(host_wr && host_addr == OFS_STAT),
      .cmd_op(host_wdata), .dev1_sel(dev1_sel),
      .data_rd(host_rd && host_addr == OFS_DATA),
      .stat_rd(host_rd && host_addr == OFS_STAT),
      .flush_done(flush_done),
      .phase(phase), .idx(idx), .err(err), .irq(irq)
   );

   always_comb begin
      status = ST_DRDY;
      if (busy_w)  status = status | ST_BSY;
      if (drq_out) status = status | ST_DRQ;
      if (err)     status = status | ST_ERR;
      if (dev1_sel) status = 8'h00;
   end

   always_comb begin
      unique case (host_addr)
         3'd0:    host_rdata = drq_out ? id_word : 16'h0000;
         3'd1:    host_rdata = {8'h00, err ? ERR_ABORT : 8'h00};
         3'd2:    host_rdata = {8'h00, shadow[7:0]};
         3'd3:    host_rdata = {8'h00, shadow[15:8]};
         3'd4:    host_rdata = {8'h00, shadow[23:16]};
         3'd5:    host_rdata = {8'h00, shadow[31:24]};
         3'd6:    host_rdata = {8'h00, shadow[39:32]};
         default: host_rdata = {8'h00, status};
      endcase
   end
endmodule

// File: rtl/taskfile_front_chk.sv
module taskfile_front_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       host_wr,
   input logic       host_rd,
   input logic [2:0] host_addr,
   input logic       flush_done,
   input logic       irq,
   input logic       drq_out,
   input logic       busy
);
   AST_IRQ_CLEARS_ON_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && host_addr == 3'd7 && !host_wr && !flush_done |=> !irq); // R6
   AST_FLUSH_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !flush_done |=> busy); // R7
   AST_FLUSH_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
      busy && flush_done |=> !busy && irq); // R7
   AST_DRQ_HELD_UNTIL_READ: assert property (@(posedge clk) disable iff (!rst_n)
      drq_out && !(host_rd && host_addr == 3'd0) |=> drq_out); // R3
   AST_IRQ_ONLY_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> !busy && !drq_out); // R5
endmodule

bind taskfile_front taskfile_front_chk u_chk (
   .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
   .host_addr(host_addr), .flush_done(flush_done), .irq(irq),
   .drq_out(drq_out), .busy(busy_w)
);

// File: tb/taskfile_front_test.sv
`timescale 1ns/1ps
module taskfile_front_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [159:0] SER = "QX7-SERIAL-0042-ZZ9K";
   localparam logic [63:0]  VER = "v2.31abc";

   logic        clk = 0;
   logic        rst_n = 0;
   logic        host_wr = 0, host_rd = 0, flush_done = 0;
   logic [2:0]  host_addr = 0;
   logic [7:0]  host_wdata = 0;
   logic [15:0] host_rdata;
   logic        irq, drq_out;

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   taskfile_front #(.SERIAL_STR(SER), .VERSION_STR(VER)) uut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .flush_done(flush_done), .irq(irq), .drq_out(drq_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // ---------------- reference model ----------------
   int       m_ph;      // 0 idle, 1 pio, 2 flush
   int       m_idx;
   bit       m_err, m_irq;
   bit [7:0] m_reg [2:6];

   function automatic [7:0] chr(input logic [159:0] s, input int nbytes, input int j);
      return s[8*nbytes-1-8*j -: 8];
   endfunction

   function automatic [15:0] exp_word(input int i);
      if (i == 0) return 16'h0040;
      if (i >= 10 && i < 20)
         return {chr(SER, 20, 2*(i-10)), chr(SER, 20, 2*(i-10)+1)};
      if (i >= 23 && i < 27)
         return {chr({96'h0, VER}, 8, 2*(i-23)), chr({96'h0, VER}, 8, 2*(i-23)+1)};
      if (i == 85) return 16'h0020;
      return 16'h0000;
   endfunction

   function automatic [15:0] m_rdata(input logic [2:0] a);
      bit [7:0] st;
      st = 8'h40;
      if (m_ph == 2) st = st + 8'h80;
      if (m_ph == 1) st = st + 8'h08;
      if (m_err)     st = st + 8'h01;
      if (m_reg[6][4]) st = 8'h00;
      case (a)
         3'd0: return (m_ph == 1) ? exp_word(m_idx) : 16'h0;
         3'd1: return m_err ? 16'h0004 : 16'h0;
         3'd7: return {8'h0, st};
         default: return {8'h0, m_reg[a]};
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_idx = 0; m_err = 0; m_irq = 0;
         for (int i = 2; i <= 6; i++) m_reg[i] = 0;
      end else begin
         bit set_irq;
         int ph0;
         set_irq = 0;
         ph0 = m_ph;
         if (ph0 == 0 && host_wr && host_addr == 7 && !m_reg[6][4]) begin
            if (host_wdata == 8'hEC) begin m_ph = 1; m_idx = 0; m_err = 0; end
            else if (host_wdata == 8'hE7) begin m_ph = 2; m_err = 0; end
            else begin m_err = 1; set_irq = 1; end
         end
         if (ph0 == 1 && host_rd && host_addr == 0) begin
            if (m_idx == 255) begin m_ph = 0; set_irq = 1; end
            else m_idx++;
         end
         if (ph0 == 2 && flush_done) begin m_ph = 0; set_irq = 1; end
         if (host_wr && host_addr >= 2 && host_addr <= 6) m_reg[host_addr] = host_wdata;
         if (set_irq) m_irq = 1;
         else if (host_rd && host_addr == 7) m_irq = 0;
      end
   end

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check("MODEL rdata", host_rdata, m_rdata(host_addr));
         check("MODEL irq", {15'h0, irq}, {15'h0, m_irq});
         check("MODEL drq", {15'h0, drq_out}, {15'h0, (m_ph == 1)});
      end
   end

   // ---------------- stimulus ----------------
   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      host_addr = a; host_wdata = d; host_wr = 1;
      @(posedge clk); #1;
      host_wr = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] v);
      @(posedge clk); #1;
      host_addr = a; host_rd = 1;
      @(negedge clk); v = host_rdata;
      @(posedge clk); #1;
      host_rd = 0;
   endtask

   task automatic pulse_flush();
      @(posedge clk); #1 flush_done = 1;
      @(posedge clk); #1 flush_done = 0;
   endtask

   task automatic finish_run();
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1 reset state
      rd(7, v); check("R1 status", v, 16'h0040);
      check("R1 irq", {15'h0, irq}, 16'h0);
      check("R1 drq", {15'h0, drq_out}, 16'h0);
      rd(4, v); check("R1 lba mid", v, 16'h0000);

      // R2 shadow registers
      wr(2, 8'h5A); wr(3, 8'h11); wr(4, 8'h22); wr(5, 8'hF3); wr(6, 8'h40);
      rd(2, v); check("R2 count", v, 16'h005A);
      rd(3, v); check("R2 lba lo", v, 16'h0011);
      rd(4, v); check("R2 lba mid", v, 16'h0022);
      rd(5, v); check("R2 lba hi", v, 16'h00F3);
      rd(6, v); check("R2 device", v, 16'h0040);

      // R11 data read outside PIO
      rd(0, v); check("R11 idle data", v, 16'h0000);
      rd(7, v); check("R11 status", v, 16'h0040);

      // R12 stray flush_done
      pulse_flush();
      check("R12 irq", {15'h0, irq}, 16'h0);
      rd(7, v); check("R12 status", v, 16'h0040);

      // R3 / R4 / R5 / R6 identify
      wr(7, 8'hEC);
      for (int i = 0; i < 256; i++) begin
         rd(7, v); check("R3 status before word", v, 16'h0048);
         rd(0, v); check("R4 word", v, exp_word(i));
      end
      check("R3 drq low", {15'h0, drq_out}, 16'h0);
      check("R5 irq after stream", {15'h0, irq}, 16'h0001);
      rd(7, v); check("R3 status after", v, 16'h0040);
      check("R6 irq cleared", {15'h0, irq}, 16'h0000);

      // R9 command during PIO ignored; no word skipped
      wr(7, 8'hEC);
      for (int i = 0; i < 100; i++) begin rd(0, v); check("R4 word", v, exp_word(i)); end
      wr(7, 8'hE7);
      rd(7, v); check("R9 status during PIO", v, 16'h0048);
      for (int i = 100; i < 256; i++) begin rd(0, v); check("R9 word continues", v, exp_word(i)); end
      rd(7, v); check("R9 status end", v, 16'h0040);

      // R7 flush
      wr(7, 8'hE7);
      rd(7, v); check("R7 pending", v, 16'h00C0);
      check("R7 irq low", {15'h0, irq}, 16'h0);
      wr(7, 8'h12);
      repeat (5) @(posedge clk);
      rd(7, v); check("R9 flush ignores cmd", v, 16'h00C0);
      rd(1, v); check("R9 no error", v, 16'h0000);
      pulse_flush();
      check("R7 irq set", {15'h0, irq}, 16'h0001);
      rd(7, v); check("R7 done status", v, 16'h0040);
      check("R6 irq cleared", {15'h0, irq}, 16'h0);

      // R8 unsupported opcode
      wr(7, 8'h5B);
      check("R8 irq", {15'h0, irq}, 16'h0001);
      rd(1, v); check("R8 error reg", v, 16'h0004);
      rd(7, v); check("R8 status", v, 16'h0041);
      wr(7, 8'hE7);
      rd(7, v); check("R8 err cleared", v, 16'h00C0);
      rd(1, v); check("R8 abort cleared", v, 16'h0000);
      pulse_flush();
      rd(7, v); check("R8 back idle", v, 16'h0040);

      // R10 device 1 absent
      wr(6, 8'h50);
      rd(7, v); check("R10 status dev1", v, 16'h0000);
      wr(7, 8'hEC);
      check("R10 no drq", {15'h0, drq_out}, 16'h0);
      wr(6, 8'h40);
      rd(7, v); check("R10 status dev0", v, 16'h0040);
      check("R10 irq", {15'h0, irq}, 16'h0);

      repeat (2) @(posedge clk);
      finish_run();
   end
endmodule